// File: doc/BRIEF.md
# Two-Block Serial EEPROM Slave Model

This block is a synthesizable model of a small serial EEPROM that answers on a two-wire I2C bus. It holds 512 bytes in on-chip RAM, split into two 256-byte blocks. A master selects the block with one bit of the control byte, and the slave keeps its own 9-bit address pointer across transactions. The bus pins are oversampled on the system clock. The slave never drives SCL. It pulls SDA low through `sda_drive_low`, which is meant to feed an open-drain pad or a wired-AND bus model.

Writes may be a single byte or a page burst that wraps inside a 16-byte page. Each data byte goes to RAM at the moment it is acknowledged. There is no busy period, and the write-protect function is treated as tied off, so writes are always accepted. Reads come in three forms: current-address reads, random reads built from a dummy write plus a repeated START, and sequential reads that run through the whole 512-byte space for as long as the master acknowledges.

The control state machine has the following states:
- `ST_IDLE`: waiting for a START.
- `ST_CTRL`: shifting in the control byte.
- `ST_CTRL_ACK`: acknowledging the control byte.
- `ST_WADDR` and `ST_WADDR_ACK`: receiving the word address and acknowledging it.
- `ST_WDATA` and `ST_WDATA_ACK`: receiving write data and acknowledging it.
- `ST_RDATA`: shifting a byte out.
- `ST_RACK`: sampling the master's acknowledge.

Transitions between states:
- A STOP leads from any state to `ST_IDLE`.
- A START leads from any state to `ST_CTRL`.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a matching device code and to `ST_IDLE` otherwise.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read and to `ST_WADDR` for a write.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state, including a repeated START, begins a new control byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The control byte is sent MSB first. Bits 7:4 must equal 4'b1010. Bits 3:2 are ignored. Bit 1 selects the block and becomes pointer bit 8. Bit 0 is the direction, where 1 means read. A matching control byte is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: A control byte with any other device code gets no acknowledge. SDA then stays released until the next START, and later bytes in that transaction neither get an acknowledge nor change the memory.
- R4: A byte write is a control byte with bit 0 = 0, then a word address, then one data byte, then a STOP. It stores the data at {block bit, word address}, and each of the three bytes is acknowledged.
- R5: In a page write, successive data bytes go to successive addresses, but only pointer bits 3:0 advance. Data past the end of a 16-byte page wraps to the start of that same page.
- R6: A random read is a write-direction control byte, then a word address, then a repeated START, then a read-direction control byte. It returns the byte stored at {block bit, word address}.
- R7: During a read, each master ACK makes the slave send the byte at the next address. The full 9-bit pointer increments, so address 0x1FF is followed by 0x000.
- R8: A current-address read (a read control byte with no word address) returns the byte at the address after the last byte read or written. The block bit is taken from the new control byte.
- R9: A master NACK after a read byte ends the read. The slave releases SDA and drives nothing for any further SCL pulses until a START.
- R10: The slave changes SDA only shortly after a detected SCL falling edge, or when a START or STOP is detected. It never changes SDA in the middle of an SCL high phase.
- R11: After reset, SDA is released, the state is idle and the address pointer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The checker watches several properties on every cycle:
- START and STOP force `ST_CTRL` and `ST_IDLE`.
- SDA is driven only in the three acknowledge states and in `ST_RDATA`.
- SDA is released in `ST_IDLE` and `ST_RACK`.
- A change on SDA always follows an SCL falling edge or a START/STOP detection.
- A page-write store leaves pointer bits 8:4 untouched.

Whether the right bytes end up at the right addresses can only be shown by the bench scenarios, which write data and read it back through the bus. These cover block selection, page wrap, the 0x1FF-to-0x000 step, current-address continuation, silence after a device-code mismatch and silence after a master NACK.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eep_state_t;

endpackage

// File: rtl/i2c_eep_line_sync.sv
module i2c_eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_lvl;

    // Synchronizer chain; idle bus level is high, so reset to 1.
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_in;
                    sda_pipe[g] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    end

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise  =  scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl &  scl_d;
    assign start_det =  scl_lvl &  scl_d &  sda_d & ~sda_lvl;
    assign stop_det  =  scl_lvl &  scl_d & ~sda_d &  sda_lvl;

endmodule

// File: rtl/i2c_eep_store.sv
module i2c_eep_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_eep_pkg::*;
#(
    parameter int         WORD_W      = 8,
    parameter int         PAGE_BITS   = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);

    localparam int ADDR_W  = WORD_W + 1;
    localparam int BLK_BIT = ADDR_W - 1;
    localparam int CNT_W   = 4;

    eep_state_t          state_q, state_d;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [BYTE_W-1:0]   rx_sh_q;
    logic [BYTE_W-1:0]   tx_sh_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic                rw_q;
    logic                nack_q;
    logic                oe_q;

    logic                sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                byte_done;
    logic                ctrl_match;
    logic                wr_en;
    logic [BYTE_W-1:0]   rd_data;

    i2c_eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_eep_store #(.AW(ADDR_W), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (ptr_q),
        .wdata (rx_sh_q),
        .raddr (ptr_q),
        .rdata (rd_data)
    );

    assign byte_done  = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));
    assign ctrl_match = (rx_sh_q[7:4] == DEV_CODE);
    assign wr_en      = (state_q == ST_WDATA) && byte_done && !start_det && !stop_det;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_CTRL;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_CTRL:      if (byte_done) state_d = ctrl_match ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = nack_q ? ST_IDLE : ST_RDATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and SDA output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            oe_q      <= 1'b0;
        end else if (stop_det || start_det) begin
            bit_cnt_q <= '0;
            oe_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CTRL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], sda_lvl};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_CTRL) begin
                            if (ctrl_match) begin
                                oe_q           <= 1'b1;
                                rw_q           <= rx_sh_q[0];
                                ptr_q[BLK_BIT] <= rx_sh_q[1];
                            end
                        end else if (state_q == ST_WADDR) begin
                            oe_q                <= 1'b1;
                            ptr_q[WORD_W-1:0]   <= rx_sh_q;
                        end else begin
                            oe_q                   <= 1'b1;
                            ptr_q[PAGE_BITS-1:0]   <= ptr_q[PAGE_BITS-1:0] + 1'b1;
                        end
                    end
                end
                ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        oe_q      <= 1'b0;
                        if (state_q == ST_CTRL_ACK && rw_q) begin
                            tx_sh_q <= rd_data;
                            oe_q    <= ~rd_data[BYTE_W-1];
                            ptr_q   <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt_q == CNT_W'(BYTE_W - 1)) begin
                            bit_cnt_q <= '0;
                            oe_q      <= 1'b0;
                        end else begin
                            tx_sh_q   <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                            oe_q      <= ~tx_sh_q[BYTE_W-2];
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_lvl;
                    end
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        oe_q      <= 1'b0;
                        if (!nack_q) begin
                            tx_sh_q <= rd_data;
                            oe_q    <= ~rd_data[BYTE_W-1];
                            ptr_q   <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_IDLE: begin
                    oe_q <= 1'b0;
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_drive_low = oe_q;

endmodule

// File: rtl/i2c_eep_checker.sv
module i2c_eep_checker
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_BITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input eep_state_t        state,
    input logic              sda_drive_low,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [ADDR_W-1:0] ptr
);

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));                                   // R1

    AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_CTRL));                   // R1

    AST_DRIVE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (state inside {ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA})); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low);                             // R3

    AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_drive_low);                             // R9

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS]))); // R5

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> $past(scl_fall || start_det || stop_det)); // R10

endmodule

bind i2c_eeprom_slave i2c_eep_checker #(
    .ADDR_W    (WORD_W + 1),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .sda_drive_low (sda_drive_low),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .wr_en         (wr_en),
    .ptr           (ptr_q)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;

    localparam int QTR = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int edge_viol = 0;
    int quiet_viol = 0;
    int scl_high_cnt = 0;
    logic quiet = 1'b0;
    logic oe_prev = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line = sda_m & ~sda_drive_low;

    i2c_eeprom_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low)
    );

    // Bus monitor for R10 (no SDA change mid-high) and silent windows (R3, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl) scl_high_cnt <= scl_high_cnt + 1;
            else     scl_high_cnt <= 0;
            if (sda_drive_low != oe_prev && scl && scl_high_cnt >= 6) edge_viol <= edge_viol + 1;
            if (quiet && sda_drive_low) quiet_viol <= quiet_viol + 1;
            oe_prev <= sda_drive_low;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        scl = 1'b0; q(); sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        scl = 1'b0; q(); sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; q(); sda_m = b[i]; q(); scl = 1'b1; q(); q();
        end
        scl = 1'b0; q(); sda_m = 1'b1; q(); scl = 1'b1; q();
        ack = ~sda_line;
        q();
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; q(); sda_m = 1'b1; q(); scl = 1'b1; q();
            d[i] = sda_line;
            q();
        end
        scl = 1'b0; q(); sda_m = ~give_ack; q(); scl = 1'b1; q(); q();
    endtask

    function automatic logic [7:0] ctrl(input logic [1:0] dc, input logic blk, input logic rd);
        return {4'b1010, dc, blk, rd};
    endfunction

    // Write n bytes from wbuf starting at {blk, addr}
    task automatic page_write(input string tag, input logic [1:0] dc, input logic blk,
                              input logic [7:0] addr, input int n);
        logic a;
        bus_start();
        wr_byte(ctrl(dc, blk, 1'b0), a); check({tag, " ctrl ack"}, a, 1'b1);
        wr_byte(addr, a);                check({tag, " addr ack"}, a, 1'b1);
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], a);
            check({tag, " data ack"}, a, 1'b1);
        end
        bus_stop();
    endtask

    // Random read of n bytes into rbuf; last byte NACKed
    task automatic rand_read(input logic blk, input logic [7:0] addr, input int n, input logic do_stop);
        logic a;
        bus_start();
        wr_byte(ctrl(2'b00, blk, 1'b0), a); check("R6 dummy ctrl ack", a, 1'b1);
        wr_byte(addr, a);                   check("R6 addr ack", a, 1'b1);
        bus_start();
        wr_byte(ctrl(2'b00, blk, 1'b1), a); check("R1 repeated start ctrl ack", a, 1'b1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, rbuf[i]);
        end
        if (do_stop) bus_stop();
    endtask

    task automatic t_reset();
        check("R11 sda released after reset", sda_drive_low, 1'b0);
        check("R11 bus line high after reset", sda_line, 1'b1);
    endtask

    task automatic t_byte_write();
        wbuf[0] = 8'hA5;
        page_write("R4", 2'b11, 1'b1, 8'h05, 1);   // don't-care bits set (R2)
        check("R1 released after STOP", sda_drive_low, 1'b0);
        rand_read(1'b1, 8'h05, 1, 1'b1);
        check("R6 random read blk1 0x05", rbuf[0], 8'hA5);
    endtask

    task automatic t_block_select();
        wbuf[0] = 8'h3C;
        page_write("R4", 2'b00, 1'b0, 8'h05, 1);
        rand_read(1'b0, 8'h05, 1, 1'b1);
        check("R2 block 0 byte", rbuf[0], 8'h3C);
        rand_read(1'b1, 8'h05, 1, 1'b1);
        check("R2 block 1 byte kept", rbuf[0], 8'hA5);
    endtask

    task automatic t_page_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        page_write("R5", 2'b00, 1'b0, 8'h1E, 4);
        rand_read(1'b0, 8'h1E, 2, 1'b1);
        check("R5 page byte 0x1E", rbuf[0], 8'h11);
        check("R5 page byte 0x1F", rbuf[1], 8'h22);
        rand_read(1'b0, 8'h10, 2, 1'b1);
        check("R5 wrapped byte 0x10", rbuf[0], 8'h33);
        check("R5 wrapped byte 0x11", rbuf[1], 8'h44);
    endtask

    task automatic t_seq_and_current();
        logic a;
        logic [7:0] d;
        wbuf[0] = 8'h88; wbuf[1] = 8'h99;
        page_write("R5", 2'b00, 1'b0, 8'h00, 2);
        wbuf[0] = 8'h77;
        page_write("R4", 2'b00, 1'b1, 8'hFF, 1);
        rand_read(1'b1, 8'hFF, 2, 1'b1);
        check("R7 byte at 0x1FF", rbuf[0], 8'h77);
        check("R7 wrap to 0x000", rbuf[1], 8'h88);
        bus_start();
        wr_byte(ctrl(2'b00, 1'b0, 1'b1), a);
        check("R8 current read ctrl ack", a, 1'b1);
        rd_byte(1'b0, d);
        bus_stop();
        check("R8 current address 0x001", d, 8'h99);
    endtask

    task automatic t_mismatch();
        logic a;
        quiet = 1'b1;
        bus_start();
        wr_byte(8'hB0, a); check("R3 wrong code not acked", a, 1'b0);
        wr_byte(8'h05, a); check("R3 next byte not acked", a, 1'b0);
        wr_byte(8'hFF, a); check("R3 data byte not acked", a, 1'b0);
        bus_stop();
        quiet = 1'b0;
        check("R3 sda stayed released", quiet_viol, 0);
        rand_read(1'b0, 8'h05, 1, 1'b1);
        check("R3 memory unchanged", rbuf[0], 8'h3C);
    endtask

    task automatic t_nack_release();
        logic [7:0] d;
        rand_read(1'b0, 8'h10, 1, 1'b0);
        check("R9 byte before NACK", rbuf[0], 8'h33);
        quiet = 1'b1;
        rd_byte(1'b0, d);
        quiet = 1'b0;
        bus_stop();
        check("R9 line idle after NACK", d, 8'hFF);
        check("R9 no drive after NACK", quiet_viol, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_byte_write();
        t_block_select();
        t_page_wrap();
        t_seq_and_current();
        t_mismatch();
        t_nack_release();
        check("R10 sda steady during SCL high", edge_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule